// File: doc/BRIEF.md
# Interleaved Double-Rate I/Q Sample Capture

This block sits between a shared parallel sample bus and the core of a dual-channel converter. One data clock qualifies the bus, and a word is transferred on each of its edges. One edge carries the in-phase (I) sample and the other carries the quadrature (Q) sample. The block captures the word at the rising edge and the word at the falling edge in separate registers. It groups the two words into pairs and presents each pair together on two output channels, once per clock cycle.

Three configuration inputs set the mode. The first chooses the edge that carries I. The second chooses whether I or Q is the leading member of a pair, and this decides which edge opens a pair. The third marks the incoming words as twos complement, in which case the block converts them to offset binary. The block latches the configuration only while synchronous reset is held, so a pair can never be split across two modes. The sample width is a parameter. When it is narrower than the bus, the samples come from the upper bus bits.

Top module: `ddr_iq_capture`

## Requirements
- R1: Each rising clock edge captures the upper `DATA_W` bits of `busData` into a rising-edge word, and each falling edge captures them into a falling-edge word. Every output pair holds exactly one word of each kind.
- R2: When the latched I-edge select (`cfgIRising`) is 1, `iData` comes from the rising-edge word and `qData` from the falling-edge word. When it is 0, the two are swapped.
- R3: A pair opens on the rising edge when `cfgIFirst` equals `cfgIRising`. In that case the words from rising edge n and falling edge n appear after rising edge n+1. Otherwise the pair is falling edge n followed by rising edge n+1, and it appears after rising edge n+2.
- R4: When the latched `cfgTwos` is 1, the most significant bit of each output sample is the inverse of the captured bit and all other bits are unchanged. When it is 0, the words pass through unmodified.
- R5: The configuration inputs are sampled only at rising edges where `rst` is 1. Changes to them while `rst` is 0 have no effect on the outputs.
- R6: At a rising edge with `rst` high, `pairValid`, `iData` and `qData` are all driven to 0.
- R7: After reset is released, `pairValid` first goes high after rising edge 1 in rising-opened modes and after rising edge 2 in falling-opened modes, counting the first edge with `rst` low as edge 0. After that it stays high every cycle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; both edges capture a word |
| rst | input | 1 | Synchronous reset, active high; configuration is latched while high |
| cfgIFirst | input | 1 | 1: the I word leads each pair; 0: the Q word leads |
| cfgIRising | input | 1 | 1: I is carried on the rising edge; 0: on the falling edge |
| cfgTwos | input | 1 | 1: incoming words are twos complement; 0: unsigned |
| busData | input | BUS_W | Shared interleaved sample bus |
| iData | output | DATA_W | Offset-binary I sample of the current pair |
| qData | output | DATA_W | Offset-binary Q sample of the current pair |
| pairValid | output | 1 | High when iData and qData hold a complete pair |

## Verification
The bench targets the two pairing alignments. If a design paired the falling-edge word with the wrong rising-edge word, each output would carry a sample from a neighbouring pair, or its first valid cycle would land one cycle early or late. Each of the four edge/order modes is run against a word sequence whose rising and falling values differ. A swapped I/Q routing therefore appears as a miscompare on both channels. Runs with twos conversion catch a design that inverts the wrong bit or skips the conversion. One run toggles every configuration input after reset is released, which exposes a design that tracks the inputs live rather than holding the mode latched at reset.

// File: rtl/ddr_iq_pkg.sv
`timescale 1ns/1ps
package ddr_iq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic useHold;  // pair opens on falling edge: use the held falling word
    logic iOnRise;  // I channel sourced from rising-edge word
    logic twos;     // convert twos complement to offset binary
  } iq_ctrl_t;

endpackage

// File: rtl/ddr_iq_fmt.sv
`timescale 1ns/1ps
module ddr_iq_fmt #(
  parameter int DATA_W = 14
) (
  input  logic              twos,
  input  logic [DATA_W-1:0] rawWord,
  output logic [DATA_W-1:0] obWord
);
  localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    obWord = twos ? (rawWord ^ SIGN_MASK) : rawWord;
  end
endmodule

// File: rtl/ddr_iq_ctrl.sv
`timescale 1ns/1ps
module ddr_iq_ctrl
  import ddr_iq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgIFirst,
  input  logic     cfgIRising,
  input  logic     cfgTwos,
  output iq_ctrl_t strobes,
  output logic     pairValid
);
  localparam int FILL_W = 2;

  logic              modeIFirst;
  logic              modeIRising;
  logic              modeTwos;
  logic [FILL_W-1:0] fillCnt;
  logic [FILL_W-1:0] fillNeed;

  // Configuration only follows the inputs during reset
  always_ff @(posedge clk) begin
    if (rst) begin
      modeIFirst  <= cfgIFirst;
      modeIRising <= cfgIRising;
      modeTwos    <= cfgTwos;
    end
  end

  always_comb begin
    strobes.useHold = (modeIFirst != modeIRising);
    strobes.iOnRise = modeIRising;
    strobes.twos    = modeTwos;
    fillNeed        = strobes.useHold ? FILL_W'(2) : FILL_W'(1);
  end

  // Count rising edges since release until the first pair is complete
  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt   <= '0;
      pairValid <= 1'b0;
    end else begin
      if (fillCnt != fillNeed) begin
        fillCnt <= fillCnt + FILL_W'(1);
      end
      pairValid <= (fillCnt == fillNeed);
    end
  end
endmodule

// File: rtl/ddr_iq_datapath.sv
`timescale 1ns/1ps
module ddr_iq_datapath
  import ddr_iq_pkg::*;
#(
  parameter int BUS_W  = 14,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  busData,
  input  iq_ctrl_t          strobes,
  output logic [DATA_W-1:0] iData,
  output logic [DATA_W-1:0] qData
);
  localparam int NUM_CH = 2;

  logic [DATA_W-1:0] capWord;
  logic [DATA_W-1:0] riseWord;
  logic [DATA_W-1:0] fallWord;
  logic [DATA_W-1:0] fallHold;
  logic [DATA_W-1:0] fallSrc;
  logic [DATA_W-1:0] chRaw [NUM_CH];
  logic [DATA_W-1:0] chOb  [NUM_CH];

  assign capWord = busData[BUS_W-1 -: DATA_W];

  always_ff @(posedge clk) begin
    riseWord <= capWord;
    fallHold <= fallWord;
  end

  always_ff @(negedge clk) begin
    fallWord <= capWord;
  end

  always_comb begin
    fallSrc   = strobes.useHold ? fallHold : fallWord;
    chRaw[0]  = strobes.iOnRise ? riseWord : fallSrc;  // I
    chRaw[1]  = strobes.iOnRise ? fallSrc  : riseWord; // Q
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fmt
    ddr_iq_fmt #(.DATA_W(DATA_W)) u_fmt (
      .twos    (strobes.twos),
      .rawWord (chRaw[ch]),
      .obWord  (chOb[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iData <= '0;
      qData <= '0;
    end else begin
      iData <= chOb[0];
      qData <= chOb[1];
    end
  end
endmodule

// File: rtl/ddr_iq_capture.sv
`timescale 1ns/1ps
module ddr_iq_capture
  import ddr_iq_pkg::*;
#(
  parameter int BUS_W  = 14,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgIFirst,
  input  logic              cfgIRising,
  input  logic              cfgTwos,
  input  logic [BUS_W-1:0]  busData,
  output logic [DATA_W-1:0] iData,
  output logic [DATA_W-1:0] qData,
  output logic              pairValid
);
  iq_ctrl_t strobes;

  ddr_iq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgIFirst  (cfgIFirst),
    .cfgIRising (cfgIRising),
    .cfgTwos    (cfgTwos),
    .strobes    (strobes),
    .pairValid  (pairValid)
  );

  ddr_iq_datapath #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .busData (busData),
    .strobes (strobes),
    .iData   (iData),
    .qData   (qData)
  );
endmodule

// File: rtl/ddr_iq_capture_chk.sv
`timescale 1ns/1ps
module ddr_iq_capture_chk
  import ddr_iq_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input iq_ctrl_t          strobes,
  input logic [DATA_W-1:0] iData,
  input logic [DATA_W-1:0] qData,
  input logic              pairValid
);
  logic [1:0] edgeCnt;

  always_ff @(posedge clk) begin
    if (rst) edgeCnt <= '0;
    else if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pairValid && iData == '0 && qData == '0)); // R6

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    pairValid |=> pairValid); // R7

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (edgeCnt < 2'd2) |-> !pairValid); // R7

  AST_RISE_OPEN_VALID: assert property (@(posedge clk) disable iff (rst)
    (edgeCnt == 2'd2 && !strobes.useHold) |-> pairValid); // R3

  AST_FALL_OPEN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (edgeCnt == 2'd2 && strobes.useHold) |-> !pairValid); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $stable(strobes)); // R5
endmodule

bind ddr_iq_capture ddr_iq_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobes   (strobes),
  .iData     (iData),
  .qData     (qData),
  .pairValid (pairValid)
);

// File: tb/ddr_iq_capture_tb.sv
`timescale 1ns/1ps
module ddr_iq_capture_tb;
  localparam int BUS_W  = 14;
  localparam int DATA_W = 14;
  localparam int NPAIR  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfgIFirst = 1'b0;
  logic              cfgIRising = 1'b0;
  logic              cfgTwos = 1'b0;
  logic [BUS_W-1:0]  busData = '0;
  logic [DATA_W-1:0] iData;
  logic [DATA_W-1:0] qData;
  logic              pairValid;

  int vecCnt = 0;
  int errCnt = 0;

  logic [DATA_W-1:0] riseSeq [NPAIR+2];
  logic [DATA_W-1:0] fallSeq [NPAIR+2];

  always #2 clk = ~clk;

  ddr_iq_capture #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .cfgIFirst(cfgIFirst), .cfgIRising(cfgIRising),
    .cfgTwos(cfgTwos), .busData(busData), .iData(iData), .qData(qData),
    .pairValid(pairValid)
  );

  function automatic logic [DATA_W-1:0] toOb(input logic [DATA_W-1:0] w, input logic tw);
    return tw ? (w ^ {1'b1, {(DATA_W-1){1'b0}}}) : w;
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One scenario: reset with a mode, stream NPAIR words per edge, compare
  task automatic runMode(input logic ifirst, input logic irising,
                         input logic twos, input logic flipCfg, input int seed);
    logic fallOpen;
    int   need;
    logic [DATA_W-1:0] r, f;
    fallOpen = (ifirst != irising);
    need = fallOpen ? 2 : 1;
    for (int k = 0; k < NPAIR + 2; k++) begin
      riseSeq[k] = DATA_W'((k * 37 + seed) ^ 14'h2A5A);
      fallSeq[k] = DATA_W'((k * 91 + seed * 3) ^ 14'h15A5);
    end
    @(posedge clk); #1;
    rst = 1'b1; cfgIFirst = ifirst; cfgIRising = irising; cfgTwos = twos;
    busData = BUS_W'(14'h3FFF);
    @(posedge clk); #1;
    @(posedge clk); #1;
    // R6: reset state
    check("R6 valid in reset", DATA_W'(pairValid), '0);
    check("R6 iData in reset", iData, '0);
    check("R6 qData in reset", qData, '0);
    busData = riseSeq[0];
    rst = 1'b0;
    if (flipCfg) begin
      // R5: mode inputs toggled after release must be ignored
      cfgIFirst = ~ifirst; cfgIRising = ~irising; cfgTwos = ~twos;
    end
    for (int k = 0; k < NPAIR; k++) begin
      @(posedge clk); #1;
      check(flipCfg ? "R5/R7 valid" : "R7 valid", DATA_W'(pairValid),
            DATA_W'(k >= need));
      if (k >= need) begin
        if (fallOpen) begin
          f = fallSeq[k-2]; r = riseSeq[k-1];
        end else begin
          r = riseSeq[k-1]; f = fallSeq[k-1];
        end
        // R1 R2 R3 R4: routing, pairing alignment and format
        check(flipCfg ? "R5 iData" : "R1/R2/R3/R4 iData", iData,
              toOb(irising ? r : f, twos));
        check(flipCfg ? "R5 qData" : "R1/R2/R3/R4 qData", qData,
              toOb(irising ? f : r, twos));
      end
      busData = fallSeq[k];
      @(negedge clk); #1;
      busData = riseSeq[k+1];
    end
  endtask

  task automatic testRiseOpenIFirst();   runMode(1'b1, 1'b1, 1'b0, 1'b0, 5);  endtask
  task automatic testRiseOpenQFirst();   runMode(1'b0, 1'b0, 1'b1, 1'b0, 11); endtask
  task automatic testFallOpenQFirst();   runMode(1'b0, 1'b1, 1'b1, 1'b0, 17); endtask
  task automatic testFallOpenIFirst();   runMode(1'b1, 1'b0, 1'b0, 1'b0, 23); endtask
  task automatic testCfgIgnoredRise();   runMode(1'b1, 1'b1, 1'b1, 1'b1, 29); endtask
  task automatic testCfgIgnoredFall();   runMode(1'b0, 1'b1, 1'b0, 1'b1, 31); endtask

  initial begin
    #(200000 * 4);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    testRiseOpenIFirst();
    testRiseOpenQFirst();
    testFallOpenQFirst();
    testFallOpenIFirst();
    testCfgIgnoredRise();
    testCfgIgnoredFall();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule